// File: doc/BRIEF.md
# Cascaded Fault Injection Control Stage

This block is one link in a daisy chain of controllers that drive instrumented fault units inside a design under test. Each link owns a bounded-width enable vector that is wired to its own group of fault units. A campaign starts either from a host start strobe carrying a fault identifier that matches this link's identifier, or from a one-cycle hand-off pulse sent by the previous link. At that moment the link captures a target injection cycle, a fault kind and an initial selection pattern.

Each round has three phases. A per-round counter runs from zero up to the programmed cycle. The link then drives the selection pattern onto the enable vector. A single-event upset gives a one-cycle pulse. A stuck-at fault holds the enable for a fixed hold window. After the round, the pattern is shifted one place toward the most significant bit and the counter is cleared. When the shift leaves no bit set, the link sends a one-cycle hand-off pulse to the next link and goes back to idle. Because only neighbouring links connect, a wide global enable net is never needed, and the control latency grows by one cycle per link.

Top module: `fi_ctrl_stage`

## Requirements
- R1: After reset is released, `fu_en_o` is all zeros, `adv_o` is low and the stage is idle.
- R2: In idle, a start strobe whose `fault_id_i` equals the parameter `STAGE_ID` begins a campaign. A strobe with any other identifier is ignored: no enable bit and no hand-off pulse appear.
- R3: In idle, a high `adv_i` begins a campaign using the current configuration inputs, exactly as a matching start strobe does.
- R4: If the campaign is accepted at clock edge k with target cycle T, the first enable pattern appears at the output after edge k+T+1. The enable stays zero before that.
- R5: `fault_kind_i`=1 selects an upset: each round's enable pattern is high for exactly one cycle.
- R6: `fault_kind_i`=0 selects stuck-at: each round's enable pattern is held unchanged for exactly `SA_HOLD` cycles.
- R7: Round r (counting from 0) drives the initial selection pattern shifted left by r, truncated to `EN_W` bits. Consecutive rounds are separated by one cleanup cycle, followed by a fresh T+1 cycle wait. Rounds continue until the shifted pattern is all zeros.
- R8: An all-zero initial selection pattern sends the stage straight to its finish state, with no enable ever raised.
- R9: `adv_o` rises one cycle after the last round's enable has cleared, or right after acceptance in the R8 case. It stays high for exactly one cycle, and the stage is idle on the next cycle.
- R10: Start strobes and `adv_i` pulses that arrive while a campaign is active have no effect on that campaign's outputs.
- R11: The enable vector is nonzero only during an injection window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Host start strobe |
| fault_id_i | input | ID_W | Identifier of the stage the strobe is meant for |
| inj_cycle_i | input | TIME_W | Target injection cycle within each round |
| fault_kind_i | input | 1 | 1 = single-event upset, 0 = stuck-at |
| sel_init_i | input | EN_W | Initial selection pattern |
| adv_i | input | 1 | Hand-off pulse from the previous stage |
| adv_o | output | 1 | Hand-off pulse to the next stage |
| fu_en_o | output | EN_W | Registered enable vector to the fault units |

## Verification
On every cycle, the assertions check these properties: the enable is nonzero only while the stage is injecting; a held stuck-at enable does not change; the hand-off pulse lasts one cycle and occurs only in the finish state; and the counter keeps the stage waiting until it reaches its target. The exact cycle counts need the bench's scenarios. These include the placement of each round relative to acceptance, the shifted pattern in each round, the hold length and the point where the hand-off fires. Whether wrong-identifier and mid-campaign strobes are ignored also needs those scenarios.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_INJ  = 3'd2,
    ST_NEXT = 3'd3,
    ST_FIN  = 3'd4
  } fi_state_e;
endpackage

// File: rtl/fi_cycle_timer.sv
module fi_cycle_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clr,
  input  logic              inc,
  input  logic [TIME_W-1:0] tgt_i,
  input  logic [TIME_W-1:0] hold_len_i,
  output logic              hit_o,
  output logic              hold_done_o
);
  logic [TIME_W-1:0] tgt_q;
  logic [TIME_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) tgt_q <= tgt_i;
      if (load || clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o       = (cnt_q == tgt_q);
  assign hold_done_o = (cnt_q == hold_len_i - 1'b1);
endmodule

// File: rtl/fi_sel_shifter.sv
module fi_sel_shifter #(
  parameter int EN_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            shift,
  input  logic [EN_W-1:0] sel_i,
  output logic [EN_W-1:0] sel_o,
  output logic            init_zero_o,
  output logic            next_zero_o
);
  logic [EN_W-1:0] sel_q;
  logic [EN_W-1:0] shifted;

  assign shifted = {sel_q[EN_W-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (load) sel_q <= sel_i;
    else if (shift) sel_q <= shifted;
  end

  assign sel_o       = sel_q;
  assign init_zero_o = (sel_i == '0);
  assign next_zero_o = (shifted == '0);
endmodule

// File: rtl/fi_stage_fsm.sv
module fi_stage_fsm
  import fi_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      go_i,
  input  logic      init_zero_i,
  input  logic      hit_i,
  input  logic      hold_done_i,
  input  logic      next_zero_i,
  output fi_state_e state_o,
  output logic      load_o,
  output logic      clr_o,
  output logic      inc_o,
  output logic      shift_o,
  output logic      fire_o,
  output logic      drop_o,
  output logic      fin_enter_o
);
  fi_state_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  always_comb begin
    st_d    = st_q;
    load_o  = 1'b0;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    shift_o = 1'b0;
    fire_o  = 1'b0;
    drop_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go_i) begin
        load_o = 1'b1;
        st_d   = init_zero_i ? ST_FIN : ST_WAIT;
      end
      ST_WAIT: if (hit_i) begin
        fire_o = 1'b1;
        clr_o  = 1'b1;
        st_d   = ST_INJ;
      end else begin
        inc_o = 1'b1;
      end
      ST_INJ: if (hold_done_i) begin
        drop_o = 1'b1;
        st_d   = ST_NEXT;
      end else begin
        inc_o = 1'b1;
      end
      ST_NEXT: begin
        shift_o = 1'b1;
        clr_o   = 1'b1;
        st_d    = next_zero_i ? ST_FIN : ST_WAIT;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign state_o     = st_q;
  assign fin_enter_o = (st_d == ST_FIN) && (st_q != ST_FIN);
endmodule

// File: rtl/fi_ctrl_stage.sv
module fi_ctrl_stage
  import fi_pkg::*;
#(
  parameter int EN_W     = 16,
  parameter int ID_W     = 8,
  parameter int TIME_W   = 16,
  parameter int SA_HOLD  = 4,
  parameter int STAGE_ID = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ID_W-1:0]   fault_id_i,
  input  logic [TIME_W-1:0] inj_cycle_i,
  input  logic              fault_kind_i,
  input  logic [EN_W-1:0]   sel_init_i,
  input  logic              adv_i,
  output logic              adv_o,
  output logic [EN_W-1:0]   fu_en_o
);
  localparam logic [ID_W-1:0]   MY_ID   = ID_W'(STAGE_ID);
  localparam logic [TIME_W-1:0] SA_LEN  = TIME_W'(SA_HOLD);
  localparam logic [TIME_W-1:0] SEU_LEN = TIME_W'(1);

  fi_state_e       state_q;
  logic            go, load, clr, inc, shift, fire, drop, fin_enter;
  logic            hit, hold_done, init_zero, next_zero;
  logic            kind_q;
  logic [EN_W-1:0] sel_q;
  logic [TIME_W-1:0] hold_len;

  assign go       = (start_i && (fault_id_i == MY_ID)) || adv_i;
  assign hold_len = kind_q ? SEU_LEN : SA_LEN;

  always_ff @(posedge clk) begin
    if (rst) kind_q <= 1'b0;
    else if (load) kind_q <= fault_kind_i;
  end

  fi_stage_fsm u_fsm (
    .clk(clk), .rst(rst), .go_i(go), .init_zero_i(init_zero),
    .hit_i(hit), .hold_done_i(hold_done), .next_zero_i(next_zero),
    .state_o(state_q), .load_o(load), .clr_o(clr), .inc_o(inc),
    .shift_o(shift), .fire_o(fire), .drop_o(drop), .fin_enter_o(fin_enter)
  );

  fi_cycle_timer #(.TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .clr(clr), .inc(inc),
    .tgt_i(inj_cycle_i), .hold_len_i(hold_len),
    .hit_o(hit), .hold_done_o(hold_done)
  );

  fi_sel_shifter #(.EN_W(EN_W)) u_sel (
    .clk(clk), .rst(rst), .load(load), .shift(shift), .sel_i(sel_init_i),
    .sel_o(sel_q), .init_zero_o(init_zero), .next_zero_o(next_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fu_en_o <= '0;
      adv_o   <= 1'b0;
    end else begin
      if (fire)      fu_en_o <= sel_q;
      else if (drop) fu_en_o <= '0;
      adv_o <= fin_enter;
    end
  end
endmodule

// File: rtl/fi_ctrl_stage_chk.sv
module fi_ctrl_stage_chk
  import fi_pkg::*;
#(
  parameter int EN_W = 16
) (
  input logic            clk,
  input logic            rst,
  input fi_state_e       state_q,
  input logic            hit,
  input logic            kind_q,
  input logic            adv_o,
  input logic [EN_W-1:0] fu_en_o
);
  // R11: enable only inside an injection window
  p_en_in_window_r11: assert property (@(posedge clk) disable iff (rst)
    (fu_en_o != '0) |-> (state_q == ST_INJ));

  // R7: every injection window drives a nonzero pattern
  p_inj_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_INJ) |-> (fu_en_o != '0));

  // R6: stuck-at enable held steady while the window lasts
  p_sa_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_INJ && !kind_q) |=> (state_q != ST_INJ) || $stable(fu_en_o));

  // R5: upset window ends after one cycle
  p_seu_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_INJ && kind_q) |=> (state_q == ST_NEXT));

  // R9: hand-off pulse lasts one cycle and belongs to the finish state
  p_adv_single_r9: assert property (@(posedge clk) disable iff (rst)
    adv_o |=> !adv_o);
  p_adv_in_fin_r9: assert property (@(posedge clk) disable iff (rst)
    adv_o |-> (state_q == ST_FIN));

  // R4: waiting continues until the counter reaches its target
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !hit) |=> (state_q == ST_WAIT));
endmodule

bind fi_ctrl_stage fi_ctrl_stage_chk #(.EN_W(EN_W)) u_chk (
  .clk(clk), .rst(rst), .state_q(state_q), .hit(hit), .kind_q(kind_q),
  .adv_o(adv_o), .fu_en_o(fu_en_o)
);

// File: tb/sim_fi_ctrl_stage.sv
module sim_fi_ctrl_stage;
  localparam int CLK      = 10;
  localparam int EN_W     = 16;
  localparam int ID_W     = 8;
  localparam int TIME_W   = 16;
  localparam int SA_HOLD  = 4;
  localparam int STAGE_ID = 3;

  typedef struct {
    logic [EN_W-1:0] en;
    logic            adv;
    string           tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [ID_W-1:0]   fault_id_i = '0;
  logic [TIME_W-1:0] inj_cycle_i = '0;
  logic              fault_kind_i = 1'b0;
  logic [EN_W-1:0]   sel_init_i = '0;
  logic              adv_i = 1'b0;
  logic              adv_o;
  logic [EN_W-1:0]   fu_en_o;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK/2) clk = ~clk;

  fi_ctrl_stage #(.EN_W(EN_W), .ID_W(ID_W), .TIME_W(TIME_W),
                  .SA_HOLD(SA_HOLD), .STAGE_ID(STAGE_ID)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .fault_id_i(fault_id_i),
    .inj_cycle_i(inj_cycle_i), .fault_kind_i(fault_kind_i),
    .sel_init_i(sel_init_i), .adv_i(adv_i), .adv_o(adv_o), .fu_en_o(fu_en_o)
  );

  // Monitor: one expected item per cycle, sampled a quarter period after the edge
  always @(posedge clk) begin
    #(CLK/4);
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (fu_en_o !== e.en || adv_o !== e.adv) begin
        n_fail++;
        $display("FAIL %s: en=%h adv=%b expected en=%h adv=%b",
                 e.tag, fu_en_o, adv_o, e.en, e.adv);
      end
    end
  end

  // Expected trace from the acceptance edge (m = 0) until one idle cycle after the hand-off
  task automatic push_expected(input logic kind, input int t,
                               input logic [EN_W-1:0] sel, input string tag);
    int lo, rounds, h, p, last_fall;
    exp_t e;
    if (sel == '0) begin                       // R8 path
      e.en = '0; e.adv = 1'b1; e.tag = {tag, "/R8"}; sb.push_back(e);
      e.adv = 1'b0; sb.push_back(e);
      return;
    end
    lo = 0;
    while (!sel[lo]) lo++;
    rounds = EN_W - lo;                         // R7
    h = kind ? 1 : SA_HOLD;                     // R5 / R6
    p = t + 2 + h;
    last_fall = t + 1 + (rounds - 1) * p + h;
    for (int m = 0; m < last_fall + 3; m++) begin
      e.en = '0; e.adv = 1'b0;
      e.tag = {tag, "/R4"};
      for (int r = 0; r < rounds; r++) begin
        int f;
        f = t + 1 + r * p;
        if (m >= f && m < f + h) begin
          e.en  = sel << r;
          e.tag = kind ? {tag, "/R5"} : {tag, "/R6"};
        end
      end
      if (m == last_fall + 1) begin
        e.adv = 1'b1; e.tag = {tag, "/R9"};
      end
      sb.push_back(e);
    end
  endtask

  task automatic set_cfg(input logic [ID_W-1:0] id, input logic kind,
                         input int t, input logic [EN_W-1:0] sel);
    fault_id_i   = id;
    fault_kind_i = kind;
    inj_cycle_i  = TIME_W'(t);
    sel_init_i   = sel;
  endtask

  task automatic wait_drain();
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_start(input logic kind, input int t,
                           input logic [EN_W-1:0] sel, input string tag);
    @(negedge clk);
    set_cfg(ID_W'(STAGE_ID), kind, t, sel);
    start_i = 1'b1;
    push_expected(kind, t, sel, tag);
    @(negedge clk);
    start_i = 1'b0;
    wait_drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: outputs quiet after reset
    n_chk++;
    if (fu_en_o !== '0 || adv_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: en=%h adv=%b expected en=0 adv=0", fu_en_o, adv_o);
    end

    // R2 R5 R7: upset, two rounds from the top bits
    run_start(1'b1, 2, 16'h4000, "R2");
    // R6 R7: stuck-at, pattern walks across all sixteen positions
    run_start(1'b0, 3, 16'h0003, "R7");
    // R8: empty pattern finishes at once
    run_start(1'b1, 5, 16'h0000, "R8");
    // R7: zero target, multi-bit pattern
    run_start(1'b1, 0, 16'h8001, "R7");

    // R2: wrong identifier ignored, no enable and no hand-off
    @(negedge clk);
    set_cfg(ID_W'(STAGE_ID + 1), 1'b1, 1, 16'hFFFF);
    start_i = 1'b1;
    for (int i = 0; i < 30; i++) begin
      exp_t e;
      e.en = '0; e.adv = 1'b0; e.tag = "R2";
      sb.push_back(e);
    end
    @(negedge clk);
    start_i = 1'b0;
    wait_drain();

    // R3: hand-off input starts a campaign
    @(negedge clk);
    set_cfg('0, 1'b1, 0, 16'hC000);
    adv_i = 1'b1;
    push_expected(1'b1, 0, 16'hC000, "R3");
    @(negedge clk);
    adv_i = 1'b0;
    wait_drain();

    // R10: strobes during an active campaign are ignored
    @(negedge clk);
    set_cfg(ID_W'(STAGE_ID), 1'b0, 1, 16'h8000);
    start_i = 1'b1;
    push_expected(1'b0, 1, 16'h8000, "R10");
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    set_cfg(ID_W'(STAGE_ID), 1'b1, 0, 16'hFFFF);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    adv_i = 1'b1;
    @(negedge clk);
    adv_i = 1'b0;
    wait_drain();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule